// File: doc/BRIEF.md
# Escalating Expiration Watchdog

The block watches one of several external periodic timer lines and counts how many times that timer expires while the watchdog is armed. Each expiration raises an expiration level by one. As the level climbs, five responses come into force in a fixed order. Three are interrupts: a local interrupt, a fast interrupt and a remote interrupt. The last two are resets: a debug reset and a power-on reset. Software keeps the level at zero by petting the watchdog at regular intervals. If software stops petting, the responses arrive one after another until the system is reset.

Each response has an enable bit. Each also has a 3-bit skip count, which holds the response back for that many extra expirations. A comparator drives an error line once the level reaches a programmed threshold. The counter can only be stopped after a 16-bit key has been written. The key is consumed by the next command write.

Software uses a plain register port: a write strobe, an address, write data, and combinational read data. There is no streaming data path, so the block has no valid/ready handshake, and a register write always takes effect on the cycle of its strobe. The timer lines and all outputs are ordinary level signals.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, the config register reads 0x0070_0000, status and skip read 0, all five stage outputs are low and `err_out` is low.
- R2: The register offsets are config 0x00, status 0x04, command 0x08, unlock 0x0C and skip 0x10. Status bit 0 reads 1 while the counter runs. Status bit 1 reads 1 while any interrupt output is high.
- R3: Writing command bit 0 starts the counter. While it runs, each rising edge on the tick line selected by config[3:0] adds one to the level. A line held high counts once, and the unselected lines have no effect.
- R4: The stages, in order, are local (config bit 12), fast (13), remote (14), debug reset (15) and power-on reset (16). Stage i fires when the level reaches the sum over j≤i of (1 + skip_j), but only if its enable bit is set. A disabled stage still uses up its levels.
- R5: Stage i takes its skip count from skip register bits [4i+2:4i]. That count delays the stage, and every later stage, by that many expirations.
- R6: Command bit 1 stops the counter only if the last write to the unlock register had 0xC45A in bits [15:0] and no command write has come since. A write of any other value clears the key.
- R7: A stop returns the level to zero and clears the three interrupt outputs. One write of command value 3, made with a valid key, restarts counting from zero.
- R8: Once the debug-reset or power-on-reset output goes high, it stays high until `rst_n` is asserted.
- R9: `err_out` is high exactly while the level is greater than or equal to config[22:20].
- R10: While the counter runs, writes to the config and skip registers are ignored.
- R11: If config bit 4 is 0, only the first expiration after a start is counted. If bit 4 is 1, counting continues on every expiration.
- R12: Bit 1 of the status register tracks the interrupt outputs: it is high while any of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_in | input | NUM_TICKS | Expiry lines from the external timers |
| irq_local | output | 1 | Local interrupt stage |
| irq_fast | output | 1 | Fast interrupt stage |
| irq_remote | output | 1 | Remote interrupt stage |
| rst_debug | output | 1 | Debug reset stage, sticky |
| rst_por | output | 1 | Power-on reset stage, sticky |
| err_out | output | 1 | Level has reached the error threshold |

## Verification
The level counter is driven with several tick patterns:
- Single pulses on the selected line, with every stage enabled, to show the fixed stage order.
- Pulses on other lines and a pulse held high for several cycles, to show that only rising edges on the selected line count.
- A run with only one stage enabled, to show that disabled stages still use up their levels.
- Runs with non-zero skip counts in two positions, to show that the thresholds move by the cumulative skip.
- A one-shot run, to show that counting halts after the first expiration.

Command sequences check that the key is honoured: no key, a correct key followed by a wrong one, and a key consumed by a start. Pets confirm that the interrupts clear while the reset stages stay high.

// File: rtl/wde_pkg.sv
package wde_pkg;
  localparam int unsigned NUM_STAGES = 5;
  localparam int unsigned SKIP_W     = 3;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 32;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SKIP = 5'h10;

  localparam logic [15:0] UNLOCK_KEY = 16'hC45A;

  localparam int unsigned CFG_PERIODIC = 4;
  localparam int unsigned CFG_EN_LSB   = 12;
  localparam int unsigned CFG_THR_LSB  = 20;
  localparam int unsigned CFG_THR_W    = 3;
  localparam logic [DATA_W-1:0] CFG_RESET = 32'h0070_0000;
  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h0071_F01F;

  typedef enum logic [2:0] {
    STG_LOCAL, STG_FAST, STG_REMOTE, STG_DEBUG, STG_POR
  } stage_e;

  function automatic logic [DATA_W-1:0] skip_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NUM_STAGES); i++) m[4*i +: SKIP_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SKIP_MASK = skip_mask_f();
endpackage

// File: rtl/wde_regs.sv
module wde_regs
  import wde_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       running,
  input  logic                       irq_pending,
  output logic [SEL_W-1:0]           tick_sel,
  output logic                       periodic,
  output logic [NUM_STAGES-1:0]      stage_en,
  output logic [CFG_THR_W-1:0]       err_thr,
  output logic [NUM_STAGES*SKIP_W-1:0] skip_cnt,
  output logic                       cmd_start,
  output logic                       cmd_stop
);
  logic [DATA_W-1:0] cfg_q, skip_q;
  logic              key_ok_q;
  logic              wr_cfg, wr_cmd, wr_key, wr_skip;

  assign wr_cfg  = bus_we && (bus_addr == OFS_CFG);
  assign wr_cmd  = bus_we && (bus_addr == OFS_CMD);
  assign wr_key  = bus_we && (bus_addr == OFS_KEY);
  assign wr_skip = bus_we && (bus_addr == OFS_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      skip_q   <= '0;
      key_ok_q <= 1'b0;
    end else begin
      if (wr_cfg && !running)  cfg_q  <= bus_wdata & CFG_MASK;
      if (wr_skip && !running) skip_q <= bus_wdata & SKIP_MASK;
      if (wr_key)      key_ok_q <= (bus_wdata[15:0] == UNLOCK_KEY);
      else if (wr_cmd) key_ok_q <= 1'b0;
    end
  end

  assign cmd_start = wr_cmd && bus_wdata[0];
  assign cmd_stop  = wr_cmd && bus_wdata[1] && key_ok_q;

  assign tick_sel = cfg_q[SEL_W-1:0];
  assign periodic = cfg_q[CFG_PERIODIC];
  assign stage_en = cfg_q[CFG_EN_LSB +: NUM_STAGES];
  assign err_thr  = cfg_q[CFG_THR_LSB +: CFG_THR_W];

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_skip
    assign skip_cnt[SKIP_W*i +: SKIP_W] = skip_q[4*i +: SKIP_W];
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CFG:  bus_rdata = cfg_q;
      OFS_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, irq_pending, running};
      OFS_SKIP: bus_rdata = skip_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R10: while running, config is frozen
  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(cfg_q));
  // R10: skip is frozen too
  assert_skip_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(skip_q));
endmodule

// File: rtl/wde_level.sv
module wde_level #(
  parameter int unsigned NUM_TICKS = 16,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned LVL_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TICKS-1:0] tick_in,
  input  logic [SEL_W-1:0]     tick_sel,
  input  logic                 periodic,
  input  logic                 cmd_start,
  input  logic                 cmd_stop,
  output logic                 running,
  output logic [LVL_W-1:0]     lvl,
  output logic                 adv
);
  logic             line, prev_q, running_q;
  logic [LVL_W-1:0] lvl_q;

  assign line = tick_in[tick_sel];
  assign adv  = running_q && line && !prev_q && !(&lvl_q) && !cmd_stop
                && (periodic || (lvl_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      running_q <= 1'b0;
      lvl_q     <= '0;
    end else begin
      prev_q <= line;
      if (cmd_stop) begin
        running_q <= 1'b0;
        lvl_q     <= '0;
      end else if (adv) begin
        lvl_q <= lvl_q + LVL_W'(1);
      end
      if (cmd_start) running_q <= 1'b1;
    end
  end

  assign running = running_q;
  assign lvl     = lvl_q;

  // R3: level moves by at most one per cycle unless stopped
  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stop |=> (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + LVL_W'(1)));
  // R7: a stop zeroes the level
  assert_stop_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (lvl_q == '0));
  // R6: counter halts only through an accepted stop
  assert_halt_by_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !cmd_stop) |=> running_q);
endmodule

// File: rtl/wde_stages.sv
module wde_stages
  import wde_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LVL_W-1:0]             lvl,
  input  logic                         adv,
  input  logic                         cmd_stop,
  input  logic [NUM_STAGES-1:0]        stage_en,
  input  logic [NUM_STAGES*SKIP_W-1:0] skip_cnt,
  output logic [NUM_STAGES-1:0]        fired
);
  logic [LVL_W-1:0] cum  [NUM_STAGES];
  logic [LVL_W-1:0] nxt;

  assign nxt = lvl + LVL_W'(1);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign cum[i] = LVL_W'(1) + LVL_W'(skip_cnt[SKIP_W*i +: SKIP_W]);
    end else begin : g_next
      assign cum[i] = cum[i-1] + LVL_W'(1) + LVL_W'(skip_cnt[SKIP_W*i +: SKIP_W]);
    end

    logic hit;
    assign hit = adv && stage_en[i] && (nxt == cum[i]);

    if (i <= int'(STG_REMOTE)) begin : g_irq
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fired[i] <= 1'b0;
        else if (cmd_stop) fired[i] <= 1'b0;
        else if (hit)      fired[i] <= 1'b1;
      end
      // R7: a stop clears interrupt stages
      assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> !fired[i]);
    end else begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fired[i] <= 1'b0;
        else if (hit) fired[i] <= 1'b1;
      end
      // R8: reset stages never drop outside reset
      assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fired[i] |=> fired[i]);
    end
  end

  // R4: at most one stage newly fires per expiration
  assert_one_new_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fired & ~$past(fired)) || $past(cmd_stop));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wde_pkg::*;
#(
  parameter int unsigned NUM_TICKS = 16,
  parameter int unsigned LVL_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_TICKS-1:0] tick_in,
  output logic                 irq_local,
  output logic                 irq_fast,
  output logic                 irq_remote,
  output logic                 rst_debug,
  output logic                 rst_por,
  output logic                 err_out
);
  localparam int unsigned SEL_W = (NUM_TICKS > 1) ? $clog2(NUM_TICKS) : 1;

  logic [SEL_W-1:0]              tick_sel;
  logic                          periodic, running, adv, cmd_start, cmd_stop;
  logic [NUM_STAGES-1:0]         stage_en, fired;
  logic [CFG_THR_W-1:0]          err_thr;
  logic [NUM_STAGES*SKIP_W-1:0]  skip_cnt;
  logic [LVL_W-1:0]              lvl;
  logic                          irq_pending;

  assign irq_pending = |fired[int'(STG_REMOTE):0];

  wde_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .running(running),
    .irq_pending(irq_pending), .tick_sel(tick_sel), .periodic(periodic),
    .stage_en(stage_en), .err_thr(err_thr), .skip_cnt(skip_cnt),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop)
  );

  wde_level #(.NUM_TICKS(NUM_TICKS), .SEL_W(SEL_W), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_sel(tick_sel),
    .periodic(periodic), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .running(running), .lvl(lvl), .adv(adv)
  );

  wde_stages #(.LVL_W(LVL_W)) u_stages (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .adv(adv), .cmd_stop(cmd_stop),
    .stage_en(stage_en), .skip_cnt(skip_cnt), .fired(fired)
  );

  assign irq_local  = fired[STG_LOCAL];
  assign irq_fast   = fired[STG_FAST];
  assign irq_remote = fired[STG_REMOTE];
  assign rst_debug  = fired[STG_DEBUG];
  assign rst_por    = fired[STG_POR];
  assign err_out    = (lvl >= LVL_W'(err_thr));

  // R9: error can only rise on an expiration
  assert_err_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_out) |-> ($past(adv) || $past(bus_we)));
endmodule

// File: tb/tb_wdog_escalate.sv
`timescale 1ns/1ps
module tb_wdog_escalate;
  localparam int NT = 16;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NT-1:0] tick_in = '0;
  logic irq_local, irq_fast, irq_remote, rst_debug, rst_por, err_out;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  wdog_escalate #(.NUM_TICKS(NT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .irq_local(irq_local), .irq_fast(irq_fast), .irq_remote(irq_remote),
    .rst_debug(rst_debug), .rst_por(rst_por), .err_out(err_out)
  );

  function automatic logic [31:0] outs();
    return {27'd0, rst_por, rst_debug, irq_remote, irq_fast, irq_local};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick_in = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(int idx);
    @(negedge clk); tick_in[idx] = 1'b1;
    @(negedge clk); tick_in[idx] = 1'b0;
  endtask

  task automatic pet();
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'd3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(5'h00, d); chk("R1 config reset", d, 32'h0070_0000);
    rd(5'h04, d); chk("R1 status reset", d, 0);
    rd(5'h10, d); chk("R1 skip reset", d, 0);
    chk("R1 outputs reset", outs(), 0);
    chk("R1 err reset", {31'd0, err_out}, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    logic [31:0] exp [5] = '{1, 3, 7, 15, 31};
    do_reset();
    wr(5'h00, 32'h0071_F012); wr(5'h08, 32'd1);
    rd(5'h04, d); chk("R2 status running", d, 1);
    pulse(0); chk("R3 unselected line", outs(), 0);
    for (int i = 0; i < 5; i++) begin
      pulse(2); chk("R4 stage order", outs(), exp[i]);
    end
  endtask

  task automatic t_skip();
    logic [31:0] exp [8] = '{0, 0, 1, 3, 3, 7, 15, 31};
    do_reset();
    wr(5'h00, 32'h0071_F010); wr(5'h10, 32'h0000_0102); wr(5'h08, 32'd1);
    for (int i = 0; i < 8; i++) begin
      pulse(0); chk("R5 skip shifts stages", outs(), exp[i]);
    end
  endtask

  task automatic t_disabled();
    do_reset();
    wr(5'h00, 32'h0070_2010); wr(5'h08, 32'd1);
    pulse(0); chk("R4 disabled stage consumes level", outs(), 0);
    pulse(0); chk("R4 fast at level 2", outs(), 2);
    pulse(0); pulse(0); pulse(0);
    chk("R4 later disabled stages silent", outs(), 2);
  endtask

  task automatic t_key();
    logic [31:0] d;
    do_reset();
    wr(5'h00, 32'h0071_F010); wr(5'h08, 32'd1);
    pulse(0);
    wr(5'h08, 32'd2);
    rd(5'h04, d); chk("R6 stop without key ignored", d, 3);
    pulse(0); chk("R6 level kept counting", outs(), 3);
    wr(5'h0C, 32'h0000_C45A); wr(5'h0C, 32'h0000_1234); wr(5'h08, 32'd2);
    rd(5'h04, d); chk("R6 wrong key clears unlock", d, 3);
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'd1); wr(5'h08, 32'd2);
    rd(5'h04, d); chk("R6 key consumed by command", d, 3);
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'd2);
    rd(5'h04, d); chk("R6 keyed stop halts", d, 0);
    pulse(0); chk("R6 stopped ignores ticks", outs(), 0);
  endtask

  task automatic t_pet();
    logic [31:0] d;
    do_reset();
    wr(5'h00, 32'h0071_F010); wr(5'h08, 32'd1);
    repeat (4) pulse(0);
    chk("R4 four expirations", outs(), 15);
    rd(5'h04, d); chk("R12 pending set", d, 3);
    pet();
    chk("R8 debug reset sticky after pet", outs(), 8);
    rd(5'h04, d); chk("R12 pending cleared by pet", d, 1);
    pulse(0); chk("R7 level restarted at zero", outs(), 9);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    wr(5'h00, 32'h0071_F010); wr(5'h08, 32'd1);
    wr(5'h00, 32'h0000_0005);
    rd(5'h00, d); chk("R10 config locked", d, 32'h0071_F010);
    wr(5'h10, 32'h0000_0007);
    rd(5'h10, d); chk("R10 skip locked", d, 0);
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'd2);
    wr(5'h00, 32'h0030_1013);
    rd(5'h00, d); chk("R10 config writable when stopped", d, 32'h0030_1013);
  endtask

  task automatic t_thr();
    do_reset();
    wr(5'h00, 32'h0021_F010); wr(5'h08, 32'd1);
    chk("R9 err low at level 0", {31'd0, err_out}, 0);
    pulse(0); chk("R9 err low at level 1", {31'd0, err_out}, 0);
    pulse(0); chk("R9 err at threshold", {31'd0, err_out}, 1);
    pulse(0); chk("R9 err above threshold", {31'd0, err_out}, 1);
    pet(); chk("R9 err cleared by pet", {31'd0, err_out}, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    do_reset();
    wr(5'h00, 32'h0071_F000); wr(5'h08, 32'd1);
    repeat (3) pulse(0);
    chk("R11 one-shot counts once", outs(), 1);
    rd(5'h04, d); chk("R11 still running", d, 3);
  endtask

  task automatic t_select();
    do_reset();
    wr(5'h00, 32'h0071_F013); wr(5'h08, 32'd1);
    pulse(0); pulse(5);
    chk("R3 other lines ignored", outs(), 0);
    @(negedge clk); tick_in[3] = 1'b1;
    repeat (4) @(negedge clk);
    tick_in[3] = 1'b0; @(negedge clk);
    chk("R3 held line counts once", outs(), 1);
    pulse(3); chk("R3 next edge counts", outs(), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset(); t_order(); t_skip(); t_disabled(); t_key();
    t_pet(); t_lock(); t_thr(); t_oneshot(); t_select();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule